// File: doc/BRIEF.md
# Aligned Burst Splitter

This block takes one transfer request at a time, described by a starting word address, a word count and a wrap flag. It breaks the request into a series of burst commands that a downstream memory sequencer can legally run. Each command carries a base word address, a beat count and a wrap flag. A beat is one 32-bit word, and addresses on both sides count words, not bytes.

For an incrementing transfer, each command uses the largest legal burst that fits three limits at once: the words still to send, the alignment of the current address, and the page limit set by the configuration. When none of 2, 4, 8 or 16 beats fits, the command is a single beat. A wrapping request goes out unchanged as one command, but only when wrapping is enabled and its length is a legal wrap length within the page limit. In every other case the wrap flag is ignored and the request is split as incrementing.

Both sides use a valid/ready handshake. The block holds a single request and takes the next one only after the downstream side has accepted the last command of the current one.

Top module: `burst_splitter`

## Requirements
- R1: After reset, `cmd_valid` is 0 and `req_ready` is 1.
- R2: Every command's `cmd_beats` (plain binary count) is 1, 2, 4, 8 or 16.
- R3: For every incrementing command (`cmd_wrap`=0) with more than one beat, `cmd_addr` is a multiple of `cmd_beats`. In bytes, the base is aligned to beats×4.
- R4: No command exceeds the page limit. `cfg_page` code 0, 1, 2 or 3 allows at most 2, 4, 8 or 16 beats. Because incrementing chunks are aligned, no chunk crosses a page boundary.
- R5: Each incrementing chunk is the largest of 16, 8, 4 and 2 that is no more than the words remaining, divides the current address and is within the page limit. If none qualifies, the chunk is 1 beat.
- R6: The commands of one request cover the request exactly. They are issued in ascending address order, each one starts where the previous one ended, and their beat counts sum to `req_len`.
- R7: When `req_wrap`=1, `cfg_wrap_en`=1, and `req_len` is 2, 4, 8 or 16 and within the page limit, the block issues exactly one command. That command has `cmd_addr`=`req_addr` (any alignment), `cmd_beats`=`req_len` and `cmd_wrap`=1. A wrap request that fails any of these conditions is split as incrementing with `cmd_wrap`=0.
- R8: When `cfg_wrap_en`=0, `req_wrap` has no effect. The commands are the same as for an incrementing request and all carry `cmd_wrap`=0.
- R9: While `cmd_valid`=1 and `cmd_ready`=0, the command fields stay unchanged on the next cycle.
- R10: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its last command is accepted. A request with `req_len`=0 is accepted and produces no command.
- R11: `cmd_valid` rises on the cycle after a request with a nonzero length is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wrap_en | input | 1 | Permits wrapping bursts |
| cfg_page | input | 2 | Page limit code: 0..3 gives 2, 4, 8 or 16 beats |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W (24) | Start word address |
| req_len | input | LEN_W (10) | Word count |
| req_wrap | input | 1 | Request asks for a wrapping burst |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Sequencer takes the command |
| cmd_addr | output | ADDR_W (24) | Burst base word address |
| cmd_beats | output | MAX_LOG+1 (5) | Beat count |
| cmd_wrap | output | 1 | Burst wraps |

## Verification
The page-limit assertion reads the live `cfg_page`, so it depends on the configuration inputs staying unchanged while a request is in progress. The bench changes `cfg_page` and `cfg_wrap_en` only while `req_ready` is high. The assertions also assume that the address plus the length of a request does not overflow the address width, and every request the bench sends stays far below that limit. `req_valid` is raised only at a negative edge where `req_ready` is expected high, and it is dropped right after acceptance.

// File: rtl/burst_splitter_pkg.sv
// Shared constants and helpers for the burst splitter.
// Assumes the largest burst is at most 2**7 beats, so a 3-bit log field is enough.
package burst_splitter_pkg;
    localparam int LOG_W = 3;

    // Turn a 2-bit page code into the log2 of the largest burst it allows.
    function automatic logic [LOG_W-1:0] page_to_log(input logic [1:0] code);
        return LOG_W'(code) + LOG_W'(1);
    endfunction
endpackage

// File: rtl/bsp_len_pick.sv
// Picks the largest legal incrementing burst length for the current position.
// Looks at the word address, the words remaining and the page limit (log2).
// Assumes rem is nonzero when the result is used. Fully combinational.
module bsp_len_pick
    import burst_splitter_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 10,
    parameter int MAX_LOG = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LEN_W-1:0]   rem,
    input  logic [LOG_W-1:0]   lim_log,
    output logic [MAX_LOG:0]   beats
);
    logic [MAX_LOG:1] fit;

    // One qualifier per candidate length 2**k.
    for (genvar k = 1; k <= MAX_LOG; k++) begin : g_fit
        localparam logic [LEN_W:0] SZ = (LEN_W+1)'(1) << k;
        assign fit[k] = ({1'b0, rem} >= SZ) &&
                        (lim_log >= LOG_W'(k)) &&
                        (addr[k-1:0] == '0);
    end

    // Take the highest qualifying length, or a single beat if none qualifies.
    always_comb begin
        beats = (MAX_LOG+1)'(1);
        for (int k = 1; k <= MAX_LOG; k++) begin
            if (fit[k]) beats = (MAX_LOG+1)'(1) << k;
        end
    end
endmodule

// File: rtl/bsp_walker.sv
// Request holder and chunk sequencer for the burst splitter.
// Takes one request, chooses wrap pass-through or incremental splitting, and steps
// the address and remaining count each time the sequencer accepts a command.
// Assumes cfg_* inputs stay stable while a request is in progress.
module bsp_walker
    import burst_splitter_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 10,
    parameter int MAX_LOG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wrap_en,
    input  logic [1:0]         cfg_page,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               req_wrap,
    input  logic [MAX_LOG:0]   pick_beats,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [LEN_W-1:0]   cur_rem,
    output logic [LOG_W-1:0]   lim_log,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [MAX_LOG:0]   cmd_beats,
    output logic               cmd_wrap
);
    logic                busy;
    logic                wrap_mode;
    logic [LOG_W-1:0]    req_lim;
    logic [LEN_W:0]      req_lim_words;
    logic                wrap_ok;
    logic                accept;
    logic                fire;
    logic                last;

    // Page limit of the incoming request, as a log and as a word count.
    assign req_lim       = page_to_log(cfg_page);
    assign req_lim_words = (LEN_W+1)'(1) << req_lim;

    // A wrap passes through only if enabled and its length is a legal power of two.
    assign wrap_ok = req_wrap && cfg_wrap_en &&
                     ($countones(req_len) == 1) &&
                     (req_len >= LEN_W'(2)) &&
                     ({1'b0, req_len} <= req_lim_words) &&
                     (req_len <= LEN_W'(1 << MAX_LOG));

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign cmd_valid = busy;
    assign fire      = cmd_valid && cmd_ready;

    // Command fields come from the held state. A wrap sends the whole remainder.
    assign cmd_addr  = cur_addr;
    assign cmd_wrap  = wrap_mode;
    assign cmd_beats = wrap_mode ? cur_rem[MAX_LOG:0] : pick_beats;
    assign last      = (cur_rem == LEN_W'(cmd_beats));

    // Load a request on acceptance, and step through the chunks on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            wrap_mode <= 1'b0;
            cur_addr  <= '0;
            cur_rem   <= '0;
            lim_log   <= '0;
        end else if (accept) begin
            busy      <= (req_len != '0);
            wrap_mode <= wrap_ok;
            cur_addr  <= req_addr;
            cur_rem   <= req_len;
            lim_log   <= req_lim;
        end else if (fire) begin
            busy      <= !last;
            cur_addr  <= cur_addr + ADDR_W'(cmd_beats);
            cur_rem   <= cur_rem - LEN_W'(cmd_beats);
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) &&
        $stable(cmd_beats) && $stable(cmd_wrap)); // R9
    AST_INC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_wrap |->
        ((cmd_addr & ADDR_W'(cmd_beats - (MAX_LOG+1)'(1))) == '0)); // R3
    AST_PAGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ({1'b0, cmd_beats} <= ((MAX_LOG+2)'(2) << cfg_page))); // R4
    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready); // R10
    AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !last |=> cmd_valid &&
        (cmd_addr == $past(cmd_addr) + ADDR_W'($past(cmd_beats)))); // R6
    AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (req_len != '0) |=> cmd_valid); // R11
endmodule

// File: rtl/burst_splitter.sv
// Top of the aligned burst splitter.
// Splits a word-addressed transfer request into legal 1/2/4/8/16-beat commands,
// or passes a legal wrapping burst through as one command.
// Assumes the configuration inputs are stable while req_ready is low.
module burst_splitter
    import burst_splitter_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 10,
    parameter int MAX_LOG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wrap_en,
    input  logic [1:0]         cfg_page,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               req_wrap,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [MAX_LOG:0]   cmd_beats,
    output logic               cmd_wrap
);
    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   cur_rem;
    logic [LOG_W-1:0]   lim_log;
    logic [MAX_LOG:0]   pick_beats;

    // Length chooser for incrementing chunks.
    bsp_len_pick #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LOG(MAX_LOG)) u_pick (
        .addr    (cur_addr),
        .rem     (cur_rem),
        .lim_log (lim_log),
        .beats   (pick_beats)
    );

    // Request state and handshakes.
    bsp_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LOG(MAX_LOG)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wrap_en (cfg_wrap_en),
        .cfg_page    (cfg_page),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .req_wrap    (req_wrap),
        .pick_beats  (pick_beats),
        .cur_addr    (cur_addr),
        .cur_rem     (cur_rem),
        .lim_log     (lim_log),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_addr    (cmd_addr),
        .cmd_beats   (cmd_beats),
        .cmd_wrap    (cmd_wrap)
    );

    AST_BEATS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($onehot(cmd_beats) &&
        (cmd_beats <= (MAX_LOG+1)'(1 << MAX_LOG)))); // R2
    AST_WRAP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_wrap |-> cfg_wrap_en && (cmd_beats != (MAX_LOG+1)'(1))); // R8
endmodule

// File: tb/burst_splitter_test.sv
// Directed bench for burst_splitter: one task per scenario, each checking its own results.
module burst_splitter_test;
    localparam int ADDR_W  = 24;
    localparam int LEN_W   = 10;
    localparam int MAX_LOG = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_wrap_en = 1'b0;
    logic [1:0]         cfg_page = 2'd3;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic               req_wrap = 1'b0;
    logic               cmd_valid;
    logic               cmd_ready = 1'b0;
    logic [ADDR_W-1:0]  cmd_addr;
    logic [MAX_LOG:0]   cmd_beats;
    logic               cmd_wrap;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    burst_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LOG(MAX_LOG)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wrap_en(cfg_wrap_en), .cfg_page(cfg_page),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_wrap(req_wrap), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_beats(cmd_beats),
        .cmd_wrap(cmd_wrap)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Greedy length from R4/R5: largest of 16,8,4,2 within remaining, alignment, page.
    function automatic int exp_len(input int a, input int rem, input int page);
        for (int b = 16; b >= 2; b = b / 2) begin
            if (b <= rem && b <= (2 << page) && (a % b) == 0) return b;
        end
        return 1;
    endfunction

    // Drive one request and check every command that follows.
    task automatic run_xfer(input int a0, input int len, input int page, input bit wrap,
                            input bit wen, input bit pass, input bit stall, input string tag);
        int a = a0;
        int rem = len;
        int sum = 0;
        int eb;
        bit first = 1'b1;
        @(negedge clk);
        cfg_page = 2'(page); cfg_wrap_en = wen;
        req_addr = ADDR_W'(a0); req_len = LEN_W'(len); req_wrap = wrap; req_valid = 1'b1;
        chk(req_ready === 1'b1, {tag, " R10 ready before request"}, req_ready, 1);
        @(posedge clk);
        while (rem > 0) begin
            @(negedge clk);
            req_valid = 1'b0;
            eb = pass ? len : exp_len(a, rem, page);
            if (first) chk(cmd_valid === 1'b1, {tag, " R11 valid after accept"}, cmd_valid, 1);
            chk(cmd_valid === 1'b1 && cmd_addr == ADDR_W'(a) && int'(cmd_beats) == eb &&
                cmd_wrap == pass, {tag, " R2 R3 R5 R7 R8 chunk addr/beats"},
                {cmd_wrap, cmd_beats, cmd_addr}, {pass, 5'(eb), 24'(a)});
            chk(req_ready === 1'b0, {tag, " R10 ready low while busy"}, req_ready, 0);
            if (stall && first) begin
                cmd_ready = 1'b0;
                @(negedge clk);
                chk(cmd_valid === 1'b1 && cmd_addr == ADDR_W'(a) && int'(cmd_beats) == eb,
                    {tag, " R9 held under stall"}, {cmd_beats, cmd_addr}, {5'(eb), 24'(a)});
            end
            first = 1'b0;
            cmd_ready = 1'b1;
            @(posedge clk);
            a += eb; rem -= eb; sum += eb;
        end
        @(negedge clk);
        req_valid = 1'b0;
        cmd_ready = 1'b0;
        chk(sum == len, {tag, " R6 beat sum"}, sum, len);
        chk(cmd_valid === 1'b0 && req_ready === 1'b1, {tag, " R10 idle after last"},
            {cmd_valid, req_ready}, 2'b01);
    endtask

    task automatic t_reset();
        chk(cmd_valid === 1'b0 && req_ready === 1'b1, "R1 reset state", {cmd_valid, req_ready}, 2'b01);
    endtask

    task automatic t_zero_len();
        @(negedge clk);
        req_addr = 24'h40; req_len = '0; req_wrap = 1'b0; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmd_valid === 1'b0 && req_ready === 1'b1, "R10 zero length gives no command",
            {cmd_valid, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_xfer(32'h100, 32, 3, 0, 0, 0, 0, "aligned_inc R5");
        run_xfer(3, 37, 3, 0, 0, 0, 0, "odd_start R5 R6");
        run_xfer(5, 1, 3, 0, 0, 0, 0, "single_word R5");
        run_xfer(0, 10, 0, 0, 0, 0, 0, "page2 R4");
        run_xfer(6, 20, 1, 0, 0, 0, 0, "page4 R4");
        run_xfer(32'h13, 8, 3, 1, 1, 1, 0, "wrap_pass R7");
        run_xfer(32'h13, 8, 3, 1, 0, 0, 0, "wrap_disabled R8");
        run_xfer(32'h20, 6, 3, 1, 1, 0, 0, "wrap_bad_len R7");
        run_xfer(32'h20, 16, 1, 1, 1, 0, 0, "wrap_over_page R7");
        run_xfer(32'h8, 24, 2, 0, 0, 0, 1, "stall R9");
        t_zero_len();
        run_xfer(32'h3F1, 47, 3, 0, 0, 0, 1, "long_mixed R6");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule